// File: doc/BRIEF.md
# Hysteresis Stop/Go Link Flow Controller

This block carries flits from a sender to a receiver buffer over a pipelined forward channel. A one-bit stop/go notice travels back over a delayed return channel. The sender holds a single permission bit. It accepts flits from its source only while that bit says go. The receiver counts how many flits its buffer holds. It issues a stop notice when that count climbs to a high watermark, and a go notice when the count falls back to a low watermark. Between the two thresholds the receiver keeps its last decision, so the return channel is quiet unless the state actually changes.

The space between the high watermark and the buffer depth absorbs the flits that are already committed when a stop is issued. These are the flits in the forward pipe plus those the sender accepts before the stop reaches it. The slack this needs is derived from the two channel latencies and checked at elaboration. A buffer of at least twice the round-trip flit count keeps the link at full rate. The receiver side is drained through a valid/ready port in arrival order.

Top module: `stopgo_link`

## Requirements
- R1: After reset the sender is in the go state (`src_ready` = 1), the receiver buffer is empty (`snk_valid` = 0) and no notice is being issued (`fc_note_valid` = 0).
- R2: A flit is taken from the source only in a cycle where `src_valid` and `src_ready` are both 1, and `src_ready` is 1 exactly while the sender is in the go state; while halted, no flit is taken however long `src_valid` is held.
- R3: When the receiver is in the go state and its occupancy reaches `HI_MARK`, it issues exactly one stop notice (`fc_note_valid` = 1 with `fc_note_stop` = 1) in the cycle after the edge at which the `HI_MARK`-th flit is written.
- R4: When the receiver is halted and its occupancy falls to `LO_MARK`, it issues one go notice (`fc_note_valid` = 1 with `fc_note_stop` = 0) in the cycle after that edge.
- R5: Notices alternate stop, go, stop and so on, and the first one is a stop. No notice is issued when occupancy stays below `HI_MARK` in the go state, even if it drops under `LO_MARK`. No notice is issued while the receiver is halted and occupancy stays above `LO_MARK`.
- R6: A notice changes `src_ready` at the `RET_LAT`+1-th rising edge after the edge that issued it. With the drain idle and the source always valid, exactly `HI_MARK` + `FWD_LAT` + `RET_LAT` + 1 flits are accepted before the sender halts.
- R7: `DEPTH` - `HI_MARK` must be at least `FWD_LAT` + `RET_LAT` + 1 and `LO_MARK` < `HI_MARK` (elaboration checks), so the receiver buffer never overflows.
- R8: The drain port presents the oldest buffered flit on `snk_data` whenever `snk_valid` = 1, removes it on a cycle with `snk_ready` = 1, and delivers flits in the exact order the source offered them.
- R9: With the drain always ready, the link accepts one flit every cycle without ever issuing a notice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Source offers a flit |
| src_data | input | FLIT_W | Flit payload from the source |
| src_ready | output | 1 | Sender is in the go state and takes the offered flit |
| snk_valid | output | 1 | Receiver buffer holds at least one flit |
| snk_data | output | FLIT_W | Oldest buffered flit |
| snk_ready | input | 1 | Drain takes the presented flit |
| fc_note_valid | output | 1 | Receiver issues a notice on the return channel this cycle |
| fc_note_stop | output | 1 | Kind of the notice: 1 stop, 0 go |

## Verification
A taken flit is written into the receiver `FWD_LAT` edges after its handshake edge. A notice is visible in the cycle after the write or read edge that crossed a watermark, and `src_ready` follows `RET_LAT`+1 edges after the notice edge. The bench drives inputs on falling edges and samples halfway through the low phase. It records the cycle index of every handshake, notice and drain, and compares those indices with the sums above instead of waiting on open-ended conditions. Flit order is checked by a running sequence counter on both the source and drain sides.

// File: rtl/stopgo_pkg.sv
package stopgo_pkg;
   typedef enum logic {
      GATE_GO   = 1'b0,
      GATE_HALT = 1'b1
   } gate_e;

   function automatic int unsigned inflight_flits(input int unsigned fwd, input int unsigned ret);
      return fwd + ret + 1;
   endfunction
endpackage

// File: rtl/stopgo_delay.sv
module stopgo_delay #(
   parameter int unsigned W   = 8,
   parameter int unsigned LAT = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   logic [W-1:0] stage [LAT];

   generate
      for (genvar s = 0; s < LAT; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= d_in;
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= stage[s-1];
            end
         end
      end
   endgenerate

   assign d_out = stage[LAT-1];
endmodule

// File: rtl/stopgo_tx.sv
module stopgo_tx
   import stopgo_pkg::*;
#(
   parameter int unsigned FLIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   input  logic [FLIT_W-1:0] src_data,
   output logic              src_ready,
   input  logic              ret_valid,
   input  logic              ret_stop,
   output logic              fwd_valid,
   output logic [FLIT_W-1:0] fwd_data
);
   gate_e gate_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         gate_q <= GATE_GO;
      else if (ret_valid) gate_q <= ret_stop ? GATE_HALT : GATE_GO;
   end

   assign src_ready = (gate_q == GATE_GO);
   assign fwd_valid = src_valid && src_ready;
   assign fwd_data  = src_data;
endmodule

// File: rtl/stopgo_rx.sv
module stopgo_rx
   import stopgo_pkg::*;
#(
   parameter int unsigned FLIT_W  = 8,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned HI_MARK = 10,
   parameter int unsigned LO_MARK = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [FLIT_W-1:0]            in_data,
   output logic                         snk_valid,
   output logic [FLIT_W-1:0]            snk_data,
   input  logic                         snk_ready,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         note_valid,
   output logic                         note_stop
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned LW = $clog2(DEPTH+1);
   localparam logic [LW-1:0] HI_L = LW'(HI_MARK);
   localparam logic [LW-1:0] LO_L = LW'(LO_MARK);

   logic [FLIT_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nx, rd_nx;
   logic [LW-1:0]     lvl_nx;
   logic              pop;
   gate_e             state_q;

   assign pop    = snk_valid && snk_ready;
   assign lvl_nx = level + LW'(in_valid) - LW'(pop);

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2_wrap
         assign wr_nx = wr_ptr + 1'b1;
         assign rd_nx = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nx = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nx = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (in_valid) mem[wr_ptr] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (in_valid) wr_ptr <= wr_nx;
         if (pop)      rd_ptr <= rd_nx;
         level <= lvl_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= GATE_GO;
         note_valid <= 1'b0;
         note_stop  <= 1'b0;
      end else if (state_q == GATE_GO && lvl_nx >= HI_L) begin
         state_q    <= GATE_HALT;
         note_valid <= 1'b1;
         note_stop  <= 1'b1;
      end else if (state_q == GATE_HALT && lvl_nx <= LO_L) begin
         state_q    <= GATE_GO;
         note_valid <= 1'b1;
         note_stop  <= 1'b0;
      end else begin
         note_valid <= 1'b0;
      end
   end

   assign snk_valid = (level != '0);
   assign snk_data  = mem[rd_ptr];
endmodule

// File: rtl/stopgo_link.sv
module stopgo_link
   import stopgo_pkg::*;
#(
   parameter int unsigned FLIT_W  = 8,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned HI_MARK = 10,
   parameter int unsigned LO_MARK = 4,
   parameter int unsigned FWD_LAT = 2,
   parameter int unsigned RET_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   input  logic [FLIT_W-1:0] src_data,
   output logic              src_ready,
   output logic              snk_valid,
   output logic [FLIT_W-1:0] snk_data,
   input  logic              snk_ready,
   output logic              fc_note_valid,
   output logic              fc_note_stop
);
   localparam int unsigned INFLIGHT = inflight_flits(FWD_LAT, RET_LAT);
   localparam int unsigned LW       = $clog2(DEPTH+1);

   generate
      if (LO_MARK >= HI_MARK) begin : g_bad_marks
         $error("stopgo_link: LO_MARK must be below HI_MARK");
      end
      if (HI_MARK > DEPTH || DEPTH - HI_MARK < INFLIGHT) begin : g_bad_slack
         $error("stopgo_link: DEPTH - HI_MARK must cover FWD_LAT + RET_LAT + 1 flits");
      end
      if (FWD_LAT < 1 || RET_LAT < 1) begin : g_bad_lat
         $error("stopgo_link: channel latencies must be at least one cycle");
      end
   endgenerate

   logic              tx_fwd_valid;
   logic [FLIT_W-1:0] tx_fwd_data;
   logic              rx_in_valid;
   logic [FLIT_W-1:0] rx_in_data;
   logic              ret_valid, ret_stop;
   logic [LW-1:0]     rx_level;

   stopgo_tx #(.FLIT_W(FLIT_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_valid (src_valid),
      .src_data  (src_data),
      .src_ready (src_ready),
      .ret_valid (ret_valid),
      .ret_stop  (ret_stop),
      .fwd_valid (tx_fwd_valid),
      .fwd_data  (tx_fwd_data)
   );

   stopgo_delay #(.W(FLIT_W+1), .LAT(FWD_LAT)) u_fwd_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({tx_fwd_valid, tx_fwd_data}),
      .d_out ({rx_in_valid, rx_in_data})
   );

   stopgo_rx #(
      .FLIT_W  (FLIT_W),
      .DEPTH   (DEPTH),
      .HI_MARK (HI_MARK),
      .LO_MARK (LO_MARK)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (rx_in_valid),
      .in_data    (rx_in_data),
      .snk_valid  (snk_valid),
      .snk_data   (snk_data),
      .snk_ready  (snk_ready),
      .level      (rx_level),
      .note_valid (fc_note_valid),
      .note_stop  (fc_note_stop)
   );

   stopgo_delay #(.W(2), .LAT(RET_LAT)) u_ret_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({fc_note_valid, fc_note_stop}),
      .d_out ({ret_valid, ret_stop})
   );
endmodule

// File: rtl/stopgo_link_chk.sv
module stopgo_link_chk #(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned HI_MARK = 10,
   parameter int unsigned LO_MARK = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       push,
   input logic                       snk_valid,
   input logic                       snk_ready,
   input logic [$clog2(DEPTH+1)-1:0] level,
   input logic                       note_valid,
   input logic                       note_stop
);
   localparam int unsigned LW = $clog2(DEPTH+1);
   logic last_stop;

   always_ff @(posedge clk) begin
      if (!rst_n)          last_stop <= 1'b0;
      else if (note_valid) last_stop <= note_stop;
   end

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !(snk_valid && snk_ready)) |-> (level < LW'(DEPTH)));

   // R3
   stop_at_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (note_valid && note_stop) |-> (level == LW'(HI_MARK)));

   // R4
   go_at_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (note_valid && !note_stop) |-> (level == LW'(LO_MARK)));

   // R5
   alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      note_valid |-> (note_stop != last_stop));

   // R8
   drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snk_valid && snk_ready && !push) |=> (level == $past(level) - 1'b1));
endmodule

bind stopgo_link stopgo_link_chk #(
   .DEPTH   (DEPTH),
   .HI_MARK (HI_MARK),
   .LO_MARK (LO_MARK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push       (rx_in_valid),
   .snk_valid  (snk_valid),
   .snk_ready  (snk_ready),
   .level      (rx_level),
   .note_valid (fc_note_valid),
   .note_stop  (fc_note_stop)
);

// File: tb/stopgo_link_bench.sv
module stopgo_link_bench;
   localparam int W     = 8;
   localparam int DEPTH = 16;
   localparam int HI    = 10;
   localparam int LO    = 4;
   localparam int FWD   = 2;
   localparam int RET   = 2;
   localparam int INFL  = FWD + RET + 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         src_valid = 1'b0;
   logic [W-1:0] src_data;
   logic         src_ready;
   logic         snk_valid;
   logic [W-1:0] snk_data;
   logic         snk_ready = 1'b0;
   logic         fc_note_valid, fc_note_stop;

   int checks = 0;
   int fails  = 0;
   int cyc = 0;
   int hs_cnt, first_hs, last_hs;
   int stop_cnt, stop_cyc, go_cnt, go_cyc;
   int pop_cnt, pop_cyc, order_err;
   logic [W-1:0] tx_seq = '0;
   logic [W-1:0] rx_seq = '0;

   always #10 clk = ~clk;

   stopgo_link #(
      .FLIT_W(W), .DEPTH(DEPTH), .HI_MARK(HI), .LO_MARK(LO),
      .FWD_LAT(FWD), .RET_LAT(RET)
   ) u_stopgo_link (
      .clk(clk), .rst_n(rst_n),
      .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
      .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
      .fc_note_valid(fc_note_valid), .fc_note_stop(fc_note_stop)
   );

   assign src_data = tx_seq;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && src_valid && src_ready) tx_seq <= tx_seq + 1'b1;
      if (rst_n && snk_valid && snk_ready) rx_seq <= rx_seq + 1'b1;
   end

   always @(negedge clk) begin
      #5;
      if (rst_n) begin
         if (src_valid && src_ready) begin
            if (hs_cnt == 0) first_hs = cyc;
            last_hs = cyc;
            hs_cnt++;
         end
         if (fc_note_valid) begin
            if (fc_note_stop) begin stop_cnt++; stop_cyc = cyc; end
            else              begin go_cnt++;   go_cyc   = cyc; end
         end
         if (snk_valid && snk_ready) begin
            pop_cnt++;
            pop_cyc = cyc;
            if (snk_data != rx_seq) order_err++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      hs_cnt = 0; first_hs = -1; last_hs = -1;
      stop_cnt = 0; stop_cyc = -1; go_cnt = 0; go_cyc = -1;
      pop_cnt = 0; pop_cyc = -1;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain_all();
      src_valid = 1'b0;
      snk_ready = 1'b1;
      tick(DEPTH + FWD + RET + 12);
      snk_ready = 1'b0;
      tick(2);
   endtask

   task automatic t_reset();
      check(src_ready == 1'b1, "R1 src_ready", int'(src_ready), 1);
      check(snk_valid == 1'b0, "R1 snk_valid", int'(snk_valid), 0);
      check(fc_note_valid == 1'b0, "R1 note", int'(fc_note_valid), 0);
   endtask

   task automatic t_stream();
      clear_mon();
      src_valid = 1'b1;
      snk_ready = 1'b1;
      tick(60);
      src_valid = 1'b0;
      tick(FWD + 6);
      snk_ready = 1'b0;
      check(hs_cnt == 60, "R9 accepted", hs_cnt, 60);
      check(pop_cnt == 60, "R9 drained", pop_cnt, 60);
      check(stop_cnt + go_cnt == 0, "R9 notices", stop_cnt + go_cnt, 0);
   endtask

   task automatic t_below_hi();
      clear_mon();
      src_valid = 1'b1;
      tick(HI - 1);
      src_valid = 1'b0;
      tick(FWD + RET + 6);
      check(hs_cnt == HI - 1, "R5 accepted", hs_cnt, HI - 1);
      check(stop_cnt == 0, "R5 no stop below HI", stop_cnt, 0);
      check(src_ready == 1'b1, "R2 still go", int'(src_ready), 1);
      snk_ready = 1'b1;
      tick(6);
      snk_ready = 1'b0;
      tick(RET + 4);
      check(go_cnt == 0, "R5 no go while go", go_cnt, 0);
      drain_all();
   endtask

   task automatic t_fill_and_resume();
      clear_mon();
      src_valid = 1'b1;
      tick(40);
      check(stop_cnt == 1, "R3 one stop", stop_cnt, 1);
      check(stop_cyc == first_hs + HI + FWD, "R3 stop cycle", stop_cyc, first_hs + HI + FWD);
      check(hs_cnt == HI + INFL, "R6 accepted before halt", hs_cnt, HI + INFL);
      check(last_hs == stop_cyc + RET, "R6 halt timing", last_hs, stop_cyc + RET);
      check(src_ready == 1'b0, "R2 halted", int'(src_ready), 0);
      clear_mon();
      snk_ready = 1'b1;
      tick(HI + INFL - LO - 1);
      snk_ready = 1'b0;
      check(go_cnt == 0, "R5 no go above LO", go_cnt, 0);
      check(hs_cnt == 0, "R2 nothing taken while halted", hs_cnt, 0);
      snk_ready = 1'b1;
      tick(1);
      snk_ready = 1'b0;
      tick(RET + 4);
      check(go_cnt == 1, "R4 one go", go_cnt, 1);
      check(go_cyc == pop_cyc + 1, "R4 go cycle", go_cyc, pop_cyc + 1);
      check(first_hs == go_cyc + RET + 1, "R6 resume timing", first_hs, go_cyc + RET + 1);
      tick(20);
      check(stop_cnt == 1, "R5 stop after go", stop_cnt, 1);
      drain_all();
      check(snk_valid == 1'b0, "R8 emptied", int'(snk_valid), 0);
      check(order_err == 0, "R8 order", order_err, 0);
      check(int'(tx_seq) == int'(rx_seq), "R8 all delivered", int'(rx_seq), int'(tx_seq));
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      order_err = 0;
      clear_mon();
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_stream();
      t_below_hi();
      t_fill_and_resume();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule